// File: doc/BRIEF.md
# Serial Audio Receiver with Word-Length Adaptation

This block receives a two-channel serial audio stream as a slave. An external master drives the bit clock and the channel-select line; the block samples channel select and serial data on every rising bit-clock edge and runs entirely in the bit-clock domain. Samples are two's complement and arrive most significant bit first. The first bit of a word follows one bit-clock period after channel select toggles, so the last bit of each word shares its period with the toggle that opens the next channel.

The transmitter and the receiver need not agree on word length. The block counts the bit-clock periods in every channel phase and reports that count. Each word is fitted into a fixed receive width set by a parameter. Bits that arrive after the receiver's least significant bit are dropped, and missing low-order bits are filled with zeros. A finished word goes to the register of its channel, with a one-cycle valid pulse, on the bit-clock edge that detects the next toggle.

Top module: `i2s_word_rx`

## Requirements
- R1: While reset is asserted, both valid outputs are low and both data outputs and the bit count read zero. Reset is asynchronous and active low.
- R2: The channel phase that is in progress when reset is released is never reported. The first valid pulse marks the end of the first phase that the block saw begin after reset.
- R3: The bit sampled on the rising edge after the edge that detects a channel-select toggle is placed in data bit RX_W-1. Each later bit of the phase goes into the next lower position.
- R4: The bit sampled on the same edge that detects a channel-select toggle is the final bit of the word that is ending, not the first bit of the next word.
- R5: A phase with channel select low is a left word and appears on leftData with leftValid. A phase with channel select high is a right word and appears on rightData with rightValid. The two valids never pulse together.
- R6: A valid output is high for exactly the one bit-clock cycle after the edge that detects the toggle ending its word. The matching data register changes only at that moment and otherwise holds its value.
- R7: When a word has more bits than RX_W, only its first RX_W bits are kept and the rest are discarded.
- R8: When a word has fewer bits than RX_W, it fills the upper positions and every lower bit is zero.
- R9: bitCount, updated together with each valid pulse, equals the number of bit-clock periods in the completed phase. The count saturates at MAX_BITS.
- R10: A word whose length equals RX_W is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial bit clock from the master; rising edge samples |
| rstN | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Channel select: low = left, high = right |
| sd | input | 1 | Serial data, MSB first |
| leftData | output | RX_W | Last received left word, fitted to RX_W |
| rightData | output | RX_W | Last received right word, fitted to RX_W |
| leftValid | output | 1 | One-cycle pulse when leftData is updated |
| rightValid | output | 1 | One-cycle pulse when rightData is updated |
| bitCount | output | $clog2(MAX_BITS+1) | Measured length of the word just delivered |

## Verification
On a single edge the block does two things. It takes in the last data bit of the closing word, and it closes that word, latches it and restarts the bit counter for the next phase. The stream exercises this overlap with words whose final bit is 1, including one-bit and two-bit words where nearly every edge is a toggle edge. The result is judged by whether that final bit lands at its expected position in the delivered word and whether the next word's count starts from one again.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  // Largest receive width the strobe struct has to address.
  localparam int unsigned RX_LIMIT = 28;
  localparam int unsigned POS_W    = $clog2(RX_LIMIT);

  // Strobes passed from the phase controller to the datapath.
  typedef struct packed {
    logic             insertEn;  // current bit lies inside the receive width
    logic [POS_W-1:0] bitPos;    // target bit position for this sample
    logic             endWord;   // toggle seen: this edge closes the word
    logic             capLeft;   // deliver the closing word as left
    logic             capRight;  // deliver the closing word as right
  } rxStrobe_t;
endpackage

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl
  import i2s_rx_pkg::*;
#(
  parameter int unsigned RX_W     = 16,
  parameter int unsigned MAX_BITS = 31,
  localparam int unsigned CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic             sck,
  input  logic             rstN,
  input  logic             ws,
  output rxStrobe_t        strobe,
  output logic [CNT_W-1:0] wordBits
);

  logic             wsD;
  logic             primed;
  logic             synced;
  logic [CNT_W-1:0] cnt;
  logic             toggle;

  // A toggle counts only once a real previous sample exists.
  assign toggle = primed & (ws ^ wsD);

  always_comb begin
    strobe.insertEn = (32'(cnt) < RX_W);
    strobe.bitPos   = POS_W'(RX_W - 1) - POS_W'(cnt);
    strobe.endWord  = toggle;
    strobe.capLeft  = toggle & synced & ~wsD;
    strobe.capRight = toggle & synced & wsD;
  end

  // cnt never exceeds MAX_BITS-1, so the closing count is at most MAX_BITS.
  assign wordBits = cnt + CNT_W'(1);

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      wsD    <= 1'b0;
      primed <= 1'b0;
      synced <= 1'b0;
      cnt    <= '0;
    end else begin
      wsD    <= ws;
      primed <= 1'b1;
      if (toggle) begin
        synced <= 1'b1;
        cnt    <= '0;
      end else if (32'(cnt) < MAX_BITS - 1) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/i2s_rx_dp.sv
module i2s_rx_dp
  import i2s_rx_pkg::*;
#(
  parameter int unsigned RX_W  = 16,
  parameter int unsigned CNT_W = 5,
  localparam int unsigned IDX_W = $clog2(RX_W)
) (
  input  logic             sck,
  input  logic             rstN,
  input  logic             sd,
  input  rxStrobe_t        strobe,
  input  logic [CNT_W-1:0] wordBits,
  output logic [RX_W-1:0]  leftData,
  output logic [RX_W-1:0]  rightData,
  output logic             leftValid,
  output logic             rightValid,
  output logic [CNT_W-1:0] bitCount
);

  logic [RX_W-1:0] shReg;
  logic [RX_W-1:0] nextWord;

  // Place the current sample; bits past the receive width are dropped.
  always_comb begin
    nextWord = shReg;
    if (strobe.insertEn) nextWord[IDX_W'(strobe.bitPos)] = sd;
  end

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      leftData   <= '0;
      rightData  <= '0;
      leftValid  <= 1'b0;
      rightValid <= 1'b0;
      bitCount   <= '0;
    end else begin
      // Clearing at word end supplies the zero fill for short words.
      shReg      <= strobe.endWord ? '0 : nextWord;
      leftValid  <= strobe.capLeft;
      rightValid <= strobe.capRight;
      if (strobe.capLeft)  leftData  <= nextWord;
      if (strobe.capRight) rightData <= nextWord;
      if (strobe.capLeft || strobe.capRight) bitCount <= wordBits;
    end
  end

endmodule

// File: rtl/i2s_word_rx.sv
module i2s_word_rx
  import i2s_rx_pkg::*;
#(
  parameter int unsigned RX_W     = 16,
  parameter int unsigned MAX_BITS = 31,
  localparam int unsigned CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic             sck,
  input  logic             rstN,
  input  logic             ws,
  input  logic             sd,
  output logic [RX_W-1:0]  leftData,
  output logic [RX_W-1:0]  rightData,
  output logic             leftValid,
  output logic             rightValid,
  output logic [CNT_W-1:0] bitCount
);

  rxStrobe_t        strobe;
  logic [CNT_W-1:0] wordBits;

  i2s_rx_ctrl #(.RX_W(RX_W), .MAX_BITS(MAX_BITS)) ctrl (
    .sck      (sck),
    .rstN     (rstN),
    .ws       (ws),
    .strobe   (strobe),
    .wordBits (wordBits)
  );

  i2s_rx_dp #(.RX_W(RX_W), .CNT_W(CNT_W)) dp (
    .sck        (sck),
    .rstN       (rstN),
    .sd         (sd),
    .strobe     (strobe),
    .wordBits   (wordBits),
    .leftData   (leftData),
    .rightData  (rightData),
    .leftValid  (leftValid),
    .rightValid (rightValid),
    .bitCount   (bitCount)
  );

endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk #(
  parameter int unsigned RX_W     = 16,
  parameter int unsigned MAX_BITS = 31,
  localparam int unsigned CNT_W   = $clog2(MAX_BITS + 1)
) (
  input logic             sck,
  input logic             rstN,
  input logic             ws,
  input logic [RX_W-1:0]  leftData,
  input logic [RX_W-1:0]  rightData,
  input logic             leftValid,
  input logic             rightValid,
  input logic [CNT_W-1:0] bitCount
);

  // R1
  reset_quiet_chk: assert property (@(posedge sck)
    !rstN |-> (!leftValid && !rightValid));

  // R5
  left_phase_chk: assert property (@(posedge sck) disable iff (!rstN)
    leftValid |-> ($past(ws, 2) == 1'b0 && $past(ws) == 1'b1));

  // R5
  right_phase_chk: assert property (@(posedge sck) disable iff (!rstN)
    rightValid |-> ($past(ws, 2) == 1'b1 && $past(ws) == 1'b0));

  // R6
  left_pulse_chk: assert property (@(posedge sck) disable iff (!rstN)
    leftValid |=> !leftValid);

  // R6
  left_hold_chk: assert property (@(posedge sck) disable iff (!rstN)
    !leftValid |-> $stable(leftData));

  // R6
  right_hold_chk: assert property (@(posedge sck) disable iff (!rstN)
    !rightValid |-> $stable(rightData));

  // R9
  count_range_chk: assert property (@(posedge sck) disable iff (!rstN)
    (leftValid || rightValid) |-> (bitCount != '0 && 32'(bitCount) <= MAX_BITS));

endmodule

bind i2s_word_rx i2s_rx_chk #(.RX_W(RX_W), .MAX_BITS(MAX_BITS)) rxChk (
  .sck        (sck),
  .rstN       (rstN),
  .ws         (ws),
  .leftData   (leftData),
  .rightData  (rightData),
  .leftValid  (leftValid),
  .rightValid (rightValid),
  .bitCount   (bitCount)
);

// File: tb/tb_i2s_word_rx.sv
module tb_i2s_word_rx;
  localparam int unsigned RX_W     = 16;
  localparam int unsigned MAX_BITS = 31;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);
  localparam int NVEC = 12;

  typedef struct packed {
    logic        ch;
    logic [7:0]  len;
    logic [39:0] val;
  } vec_t;

  // Alternating channels, starting left. Lengths span equal, long, short,
  // single-bit and saturating cases.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd16, 40'hA5C3},
    '{1'b1, 8'd16, 40'h8001},
    '{1'b0, 8'd24, 40'h123456},
    '{1'b1, 8'd28, 40'hFEDCBA9},
    '{1'b0, 8'd8,  40'h9C},
    '{1'b1, 8'd12, 40'hABC},
    '{1'b0, 8'd1,  40'h1},
    '{1'b1, 8'd2,  40'h1},
    '{1'b0, 8'd17, 40'h1FFFF},
    '{1'b1, 8'd15, 40'h7FFF},
    '{1'b0, 8'd31, 40'h5A5A1234},
    '{1'b1, 8'd36, 40'h912345678}
  };

  logic             sck = 1'b0;
  logic             rstN = 1'b0;
  logic             ws = 1'b1;
  logic             sd = 1'b0;
  logic [RX_W-1:0]  leftData, rightData;
  logic             leftValid, rightValid;
  logic [CNT_W-1:0] bitCount;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  finished = 1'b0;
  logic [RX_W-1:0] lastLeft = '0;
  logic [RX_W-1:0] lastRight = '0;

  always #5 sck = ~sck;

  i2s_word_rx #(.RX_W(RX_W), .MAX_BITS(MAX_BITS)) dut (
    .sck(sck), .rstN(rstN), .ws(ws), .sd(sd),
    .leftData(leftData), .rightData(rightData),
    .leftValid(leftValid), .rightValid(rightValid),
    .bitCount(bitCount)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [RX_W-1:0] expWord(input logic [39:0] v, input int len);
    logic [RX_W-1:0] e = '0;
    for (int k = 0; k < RX_W; k++)
      if (k < len) e[RX_W-1-k] = v[len-1-k];
    return e;
  endfunction

  task automatic driveBit(input logic w, input logic d);
    @(negedge sck);
    ws = w;
    sd = d;
  endtask

  // Bit i goes out in the period after the previous one; channel select
  // flips during the final bit, which closes the word on that edge.
  task automatic sendWord(input logic c, input logic [39:0] v, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge sck);
      if (i == 1) begin
        chk("R6 valid drops after one cycle (left)", 64'(leftValid), 64'd0);
        chk("R6 valid drops after one cycle (right)", 64'(rightValid), 64'd0);
      end
      ws = (i == len - 1) ? ~c : c;
      sd = v[len-1-i];
    end
  endtask

  task automatic checkNone(input string tag);
    @(posedge sck);
    #2;
    chk(tag, 64'({leftValid, rightValid}), 64'd0);
  endtask

  task automatic checkWord(input logic c, input logic [39:0] v, input int len);
    logic [RX_W-1:0] e;
    string fitTag;
    e = expWord(v, len);
    if (len > RX_W)       fitTag = "R7 truncate";
    else if (len < RX_W)  fitTag = "R8 zero fill";
    else                  fitTag = "R10 exact / R3 / R4";
    @(posedge sck);
    #2;
    if (c == 1'b0) begin
      chk("R5 leftValid pulse", 64'(leftValid), 64'd1);
      chk("R5 rightValid quiet", 64'(rightValid), 64'd0);
      chk(fitTag, 64'(leftData), 64'(e));
      chk("R6 rightData held", 64'(rightData), 64'(lastRight));
      lastLeft = e;
    end else begin
      chk("R5 rightValid pulse", 64'(rightValid), 64'd1);
      chk("R5 leftValid quiet", 64'(leftValid), 64'd0);
      chk(fitTag, 64'(rightData), 64'(e));
      chk("R6 leftData held", 64'(leftData), 64'(lastLeft));
      lastRight = e;
    end
    chk("R9 bit count", 64'(bitCount), 64'((len > int'(MAX_BITS)) ? int'(MAX_BITS) : len));
  endtask

  initial begin
    #22;
    // R1: outputs during reset
    chk("R1 valids in reset", 64'({leftValid, rightValid}), 64'd0);
    chk("R1 data in reset", 64'({leftData, rightData}), 64'd0);
    chk("R1 count in reset", 64'(bitCount), 64'd0);
    @(negedge sck);
    rstN = 1'b1;
    driveBit(1'b1, 1'b1);
    driveBit(1'b1, 1'b1);
    driveBit(1'b0, 1'b1);
    // R2: the phase cut by reset release is not delivered
    checkNone("R2 partial phase suppressed");

    // Main table. Entry 1 (0x8001) ends with 1 on the toggle edge: R4.
    for (int i = 0; i < NVEC; i++) begin
      sendWord(VECS[i].ch, VECS[i].val, int'(VECS[i].len));
      checkWord(VECS[i].ch, VECS[i].val, int'(VECS[i].len));
    end

    // Reset in the middle of a word.
    driveBit(1'b0, 1'b1);
    driveBit(1'b0, 1'b0);
    @(negedge sck);
    rstN = 1'b0;
    #1;
    chk("R1 async reset clears valids", 64'({leftValid, rightValid}), 64'd0);
    chk("R1 async reset clears data", 64'({leftData, rightData}), 64'd0);
    chk("R1 async reset clears count", 64'(bitCount), 64'd0);
    lastLeft = '0;
    lastRight = '0;
    ws = 1'b1;
    sd = 1'b1;
    @(negedge sck);
    @(negedge sck);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) driveBit(1'b1, 1'b1);
    driveBit(1'b0, 1'b1);
    // R2: garbage right phase after reset is never reported
    checkNone("R2 first phase after mid-run reset");
    sendWord(1'b0, 40'hC3, 8);
    checkWord(1'b0, 40'hC3, 8);
    sendWord(1'b1, 40'h1234, 16);
    checkWord(1'b1, 40'h1234, 16);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule